// File: doc/BRIEF.md
# Entropy Word Assembler

The assembler gathers 32-bit entropy words from a requester. Each word comes with a strobe. Eight accepted words form one 256-bit value. When the eighth word arrives, the block stops taking words and raises a pending flag. It then waits for a completion acknowledge from the far side of the transfer. One cycle after that acknowledge, the assembled value is copied into a consumer register and a one-cycle valid pulse is issued. The accumulator is then cleared and collection starts again.

A stall timer counts the cycles spent pending and flags a stuck transfer if no acknowledge comes in time. A flush input returns the block to an empty collecting state at any moment.

The parameter `PACK_MODE` selects how the accumulator fills:
- In direct mode (0), each accepted word appears in the accumulator at once.
- In lane mode (1), the accumulator is four 64-bit lanes. An even-numbered word is held in a staging register, and the lane is written when the odd partner arrives.

The controller has three states:
- `ST_COLLECT` accepts words.
- `ST_WAIT` is pending, awaiting the acknowledge.
- `ST_COMMIT` is the one cycle in which the consumer register loads.

Its transitions are:
- `ST_COLLECT` to `ST_WAIT` on the eighth accepted word.
- `ST_WAIT` to `ST_COMMIT` on the acknowledge.
- `ST_COMMIT` to `ST_COLLECT` always.
- Any state to `ST_COLLECT` on flush.

Top module: `ewa_assembler`

## Requirements
- R1: After reset, `word_ready` is 1, and `pending`, `value_valid` and `stall_err` are 0. `acc_view` and `value_out` are all zeros.
- R2: In direct mode, the n-th accepted word (n = 0..7) appears at bits [32n+31:32n] of `acc_view` in the cycle after it is accepted. The first word therefore sits in bits [31:0].
- R3: A word is accepted when `word_valid` is 1 while `word_ready` is 1 and `flush` is 0. After the eighth accepted word, `pending` is 1 and `word_ready` is 0 from the next cycle, and the word count restarts at 0.
- R4: Words presented while `pending` is 1 are not accepted and leave `acc_view` and the committed value unchanged.
- R5: In lane mode, lane L (bits [64L+63:64L]) is formed from word 2L in its low half and word 2L+1 in its high half. Nothing of an even word shows in `acc_view` until its odd partner is accepted. The final committed value equals the direct-mode value.
- R6: An acknowledge sampled while pending causes `value_out` to hold the assembled value in the second cycle after it. In that same cycle `pending` is 0, `word_ready` is 1 and `acc_view` is 0.
- R7: `done_ack` has no effect when no transfer is pending: there is no valid pulse and no change to `value_out` or `acc_view`.
- R8: The pending counter starts at 0 on entry and advances each pending cycle without an acknowledge.
  - An acknowledge presented within the first six pending cycles (count at most 5) leaves `stall_err` at 0.
  - Otherwise `stall_err` rises when the count would reach 6. It stays 1 through the commit until a flush, while the block keeps waiting.
- R9: `flush` has priority over a word or an acknowledge in the same cycle. In the next cycle `acc_view`, the word count, `pending`, the pending counter and `stall_err` are cleared, and `value_out` keeps its previous contents.
- R10: `value_valid` is high for exactly one cycle per commit, and `value_out` changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clear accumulator, count, pending state and error |
| word_valid | input | 1 | Entropy word strobe |
| word_data | input | 32 | Entropy word |
| word_ready | output | 1 | High while words are accepted |
| done_ack | input | 1 | Completion acknowledge for a pending value |
| pending | output | 1 | Assembled value awaiting completion |
| acc_view | output | 256 | Current accumulator contents |
| value_out | output | 256 | Consumer register |
| value_valid | output | 1 | One-cycle pulse on consumer register update |
| stall_err | output | 1 | Sticky stuck-transfer flag |

## Verification
Flush can coincide with two other functions:
- with a word strobe while collecting, and
- with the acknowledge while pending.

The bench provokes both by raising `flush` in the same cycle as `word_valid`, and in a separate test as `done_ack`. It judges them at the ports:
- After flush with a word, `acc_view` is zero, and the next full frame commits exactly its own eight words, which shows the word count restarted.
- After flush with an acknowledge, no valid pulse follows and `value_out` still holds the previous frame.

The acknowledge can also land on the sixth pending cycle, the last one the stall timer allows. The vector table places one acknowledge there and one a cycle later, and expects `stall_err` to be 0 for the first and 1 for the second.

// File: rtl/ewa_pkg.sv
package ewa_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_WAIT    = 2'd1,
        ST_COMMIT  = 2'd2
    } ewa_state_e;

    localparam int PACK_DIRECT = 0;
    localparam int PACK_LANES  = 1;
endpackage

// File: rtl/ewa_packer.sv
module ewa_packer
    import ewa_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    parameter int PACK_MODE = PACK_DIRECT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        take,
    input  logic [WORD_W-1:0]           data,
    output logic [WORD_W*NUM_WORDS-1:0] acc,
    output logic                        last_word
);
    localparam int VAL_W  = WORD_W * NUM_WORDS;
    localparam int CNT_W  = $clog2(NUM_WORDS);
    localparam int LANE_W = 2 * WORD_W;

    logic [CNT_W-1:0] wcnt;
    logic [VAL_W-1:0] acc_q;

    assign last_word = take && (wcnt == CNT_W'(NUM_WORDS - 1));
    assign acc       = acc_q;

    // word counter, wraps after the last word of a frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (clear) begin
            wcnt <= '0;
        end else if (take) begin
            wcnt <= last_word ? '0 : wcnt + 1'b1;
        end
    end

    generate
        if (PACK_MODE == PACK_LANES) begin : g_lanes
            logic [WORD_W-1:0]  stage;
            logic [CNT_W-2:0]   lane_idx;

            assign lane_idx = wcnt[CNT_W-1:1];

            // even word waits in stage; odd word writes the whole lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    acc_q <= '0;
                    stage <= '0;
                end else if (clear) begin
                    acc_q <= '0;
                    stage <= '0;
                end else if (take) begin
                    if (!wcnt[0]) begin
                        stage <= data;
                    end else begin
                        acc_q[lane_idx*LANE_W +: LANE_W] <= {data, stage};
                    end
                end
            end
        end else begin : g_direct
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    acc_q <= '0;
                end else if (clear) begin
                    acc_q <= '0;
                end else if (take) begin
                    acc_q[wcnt*WORD_W +: WORD_W] <= data;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ewa_stall_timer.sv
module ewa_stall_timer #(
    parameter int LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic err_clear,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && (cnt != CW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    // sticky: set on the cycle the count would reach LIMIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expired <= 1'b0;
        end else if (err_clear) begin
            expired <= 1'b0;
        end else if (run && (cnt == CW'(LIMIT - 1))) begin
            expired <= 1'b1;
        end
    end
endmodule

// File: rtl/ewa_commit_reg.sv
module ewa_commit_reg #(
    parameter int VAL_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VAL_W-1:0] din,
    output logic [VAL_W-1:0] dout,
    output logic             valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= load;
            if (load) begin
                dout <= din;
            end
        end
    end
endmodule

// File: rtl/ewa_assembler.sv
module ewa_assembler
    import ewa_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int NUM_WORDS  = 8,
    parameter int PACK_MODE  = PACK_DIRECT,
    parameter int STALL_LIMIT = 6,
    localparam int VAL_W     = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic              done_ack,
    output logic              pending,
    output logic [VAL_W-1:0]  acc_view,
    output logic [VAL_W-1:0]  value_out,
    output logic              value_valid,
    output logic              stall_err
);
    ewa_state_e state_q, state_d;

    logic take;
    logic last_word;
    logic pk_clear;
    logic load;
    logic t_run;
    logic t_clear;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COLLECT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_COLLECT: if (last_word) state_d = ST_WAIT;
                ST_WAIT:    if (done_ack)  state_d = ST_COMMIT;
                ST_COMMIT:  state_d = ST_COLLECT;
                default:    state_d = ST_COLLECT;
            endcase
        end
    end

    // state-decoded controls
    always_comb begin
        word_ready = 1'b0;
        pending    = 1'b0;
        load       = 1'b0;
        t_run      = 1'b0;
        unique case (state_q)
            ST_COLLECT: word_ready = 1'b1;
            ST_WAIT: begin
                pending = 1'b1;
                t_run   = !done_ack && !flush;
            end
            ST_COMMIT: begin
                pending = 1'b1;
                load    = !flush;
            end
            default: ;
        endcase
        take     = word_ready && word_valid && !flush;
        pk_clear = flush || (state_q == ST_COMMIT);
        t_clear  = flush || (state_q != ST_WAIT);
    end

    ewa_packer #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .PACK_MODE (PACK_MODE)
    ) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pk_clear),
        .take      (take),
        .data      (word_data),
        .acc       (acc_view),
        .last_word (last_word)
    );

    ewa_stall_timer #(
        .LIMIT (STALL_LIMIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (t_clear),
        .run       (t_run),
        .err_clear (flush),
        .expired   (stall_err)
    );

    ewa_commit_reg #(
        .VAL_W (VAL_W)
    ) u_commit (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (acc_view),
        .dout  (value_out),
        .valid (value_valid)
    );
endmodule

// File: rtl/ewa_assembler_chk.sv
module ewa_assembler_chk #(
    parameter int VAL_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             word_ready,
    input logic             done_ack,
    input logic             pending,
    input logic [VAL_W-1:0] acc_view,
    input logic [VAL_W-1:0] value_out,
    input logic             value_valid,
    input logic             stall_err
);
    a_r3_no_ready_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !word_ready);

    a_r4_acc_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !flush) |=> (!pending || $stable(acc_view)));

    a_r6_valid_after_pending: assert property (@(posedge clk) disable iff (!rst_n)
        value_valid |-> (!pending && $past(pending)));

    a_r7_valid_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        value_valid |-> $past(done_ack, 2));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_err && !flush) |=> stall_err);

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!pending && !stall_err && (acc_view == '0)));

    a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        value_valid |=> !value_valid);

    a_r10_value_changes_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(value_out) |-> value_valid);
endmodule

bind ewa_assembler ewa_assembler_chk #(.VAL_W(VAL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .word_ready  (word_ready),
    .done_ack    (done_ack),
    .pending     (pending),
    .acc_view    (acc_view),
    .value_out   (value_out),
    .value_valid (value_valid),
    .stall_err   (stall_err)
);

// File: tb/tb_ewa_assembler.sv
`timescale 1ns/1ps
module tb_ewa_assembler;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         word_valid = 1'b0;
    logic [31:0]  word_data = '0;
    logic         done_ack = 1'b0;

    logic         word_ready, pending, value_valid, stall_err;
    logic [255:0] acc_view, value_out;
    logic         l_ready, l_pending, l_valid, l_err;
    logic [255:0] l_acc, l_value;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [255:0] last_val = '0;

    always #2 clk = ~clk;

    ewa_assembler #(.PACK_MODE(0)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .word_valid(word_valid),
        .word_data(word_data), .word_ready(word_ready), .done_ack(done_ack),
        .pending(pending), .acc_view(acc_view), .value_out(value_out),
        .value_valid(value_valid), .stall_err(stall_err));

    ewa_assembler #(.PACK_MODE(1)) dut_lane (
        .clk(clk), .rst_n(rst_n), .flush(flush), .word_valid(word_valid),
        .word_data(word_data), .word_ready(l_ready), .done_ack(done_ack),
        .pending(l_pending), .acc_view(l_acc), .value_out(l_value),
        .value_valid(l_valid), .stall_err(l_err));

    // seed[39:8], ack delay[7:4], expected stall error [0]
    localparam logic [39:0] VEC [0:4] = '{
        {32'hA5A5_0001, 4'd0, 4'd0},
        {32'h1234_5678, 4'd2, 4'd0},
        {32'hDEAD_BEEF, 4'd5, 4'd0},
        {32'h0F0F_F0F0, 4'd6, 4'd1},
        {32'h7777_0003, 4'd9, 4'd1}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung act=%0d exp<=20000", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] wgen(input logic [31:0] seed, input int k);
        return (seed ^ (32'h0101_0101 * k)) + 32'(k);
    endfunction

    function automatic logic [255:0] frame(input logic [31:0] seed);
        logic [255:0] v = '0;
        for (int k = 0; k < 8; k++) v[32*k +: 32] = wgen(seed, k);
        return v;
    endfunction

    task automatic send_word(input logic [31:0] d);
        word_valid = 1'b1;
        word_data  = d;
        tick();
        word_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [31:0] seed, input bit gaps);
        for (int k = 0; k < 8; k++) begin
            send_word(wgen(seed, k));
            if (gaps && k[0]) tick();
        end
    endtask

    task automatic ack_and_commit(input logic [31:0] seed);
        done_ack = 1'b1;
        tick();
        done_ack = 1'b0;
        tick();
        chk(value_valid && l_valid, "R10 valid pulse", {254'd0, value_valid, l_valid}, 256'd3);
        chk(value_out == frame(seed), "R6 committed value", value_out, frame(seed));
        chk(l_value == frame(seed), "R5 lane committed value", l_value, frame(seed));
        chk(!pending && word_ready && acc_view == '0, "R6 cleared after commit",
            acc_view, 256'd0);
        last_val = frame(seed);
        tick();
        chk(!value_valid && !l_valid, "R10 single cycle", {255'd0, value_valid}, 256'd0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(word_ready && !pending && !value_valid && !stall_err,
            "R1 reset flags", {252'd0, word_ready, pending, value_valid, stall_err},
            {252'd0, 4'b1000});
        chk(acc_view == '0 && value_out == '0 && l_acc == '0, "R1 reset data",
            acc_view | value_out, 256'd0);

        // vector table: frames with varied acknowledge delay
        for (int i = 0; i < 5; i++) begin
            logic [31:0] seed = VEC[i][39:8];
            int          dly  = int'(VEC[i][7:4]);
            bit          eerr = VEC[i][0];
            send_frame(seed, i[0]);
            chk(pending && !word_ready, "R3 pending after eighth word",
                {254'd0, pending, word_ready}, 256'd2);
            repeat (dly) tick();
            chk(pending == 1'b1, "R8 still waiting", {255'd0, pending}, 256'd1);
            ack_and_commit(seed);
            chk(stall_err == eerr && l_err == eerr, "R8 stall flag",
                {255'd0, stall_err}, {255'd0, eerr});
            if (eerr) begin
                flush = 1'b1;
                tick();
                flush = 1'b0;
                chk(!stall_err, "R9 flush clears error", {255'd0, stall_err}, 256'd0);
                chk(value_out == last_val, "R9 value kept on flush", value_out, last_val);
            end
        end

        // R2 / R5 word placement and lane staging
        begin
            logic [31:0] s = 32'hC0DE_0042;
            send_word(wgen(s, 0));
            chk(acc_view == {224'd0, wgen(s, 0)}, "R2 first word low bits",
                acc_view, {224'd0, wgen(s, 0)});
            chk(l_acc == '0, "R5 even word staged", l_acc, 256'd0);
            send_word(wgen(s, 1));
            chk(acc_view[63:0] == {wgen(s, 1), wgen(s, 0)}, "R2 second word",
                acc_view, {192'd0, wgen(s, 1), wgen(s, 0)});
            chk(l_acc == {192'd0, wgen(s, 1), wgen(s, 0)}, "R5 lane 0 filled",
                l_acc, {192'd0, wgen(s, 1), wgen(s, 0)});
            send_word(wgen(s, 2));
            chk(l_acc[255:64] == '0, "R5 lane 1 waits for odd word", l_acc,
                {192'd0, wgen(s, 1), wgen(s, 0)});
            for (int k = 3; k < 8; k++) send_word(wgen(s, k));
            chk(acc_view == frame(s) && l_acc == frame(s), "R2 full frame",
                acc_view, frame(s));
            // R4 words while pending are ignored
            word_valid = 1'b1;
            word_data  = 32'hFFFF_FFFF;
            tick();
            tick();
            word_valid = 1'b0;
            chk(acc_view == frame(s) && l_acc == frame(s), "R4 ignored while pending",
                acc_view, frame(s));
            ack_and_commit(s);
        end

        // R7 acknowledge with nothing pending
        done_ack = 1'b1;
        tick();
        chk(!value_valid && value_out == last_val, "R7 idle ack no effect",
            value_out, last_val);
        tick();
        done_ack = 1'b0;
        chk(!value_valid && value_out == last_val && acc_view == '0 && word_ready,
            "R7 idle ack no commit", value_out, last_val);
        send_word(32'h0000_1111);
        done_ack = 1'b1;
        tick();
        tick();
        done_ack = 1'b0;
        chk(acc_view == {224'd0, 32'h0000_1111} && !value_valid,
            "R7 ack mid-collection ignored", acc_view, {224'd0, 32'h0000_1111});

        // R9 flush together with a word strobe
        flush      = 1'b1;
        word_valid = 1'b1;
        word_data  = 32'hBAD0_BAD0;
        tick();
        flush      = 1'b0;
        word_valid = 1'b0;
        chk(acc_view == '0 && l_acc == '0, "R9 flush beats word", acc_view, 256'd0);
        send_frame(32'h5151_A0A0, 1'b0);
        ack_and_commit(32'h5151_A0A0);

        // R9 flush together with the acknowledge
        send_frame(32'h2468_ACE0, 1'b1);
        flush    = 1'b1;
        done_ack = 1'b1;
        tick();
        flush    = 1'b0;
        done_ack = 1'b0;
        chk(!pending && word_ready && acc_view == '0, "R9 flush beats ack",
            acc_view, 256'd0);
        tick();
        chk(!value_valid, "R9 no commit after flush", {255'd0, value_valid}, 256'd0);
        tick();
        chk(value_out == last_val && !value_valid, "R9 value unchanged",
            value_out, last_val);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule